// File: doc/BRIEF.md
# Two-Phase Mailbox Doorbell

This block is the device side of a 32-bit doorbell register through which host software hands the device the location of a command mailbox in host memory. The location is wider than one register write, so the host sends it in two ordered halves. Bit 1 of each write tells the halves apart. The upper half arrives first with that bit set. The lower half follows with the bit clear. Bits 31:2 of each write carry a 30-bit fragment. The block joins the two fragments into a 60-bit mailbox address: the upper fragment forms the most significant bits.

A read-only ready flag in bit 0 paces the host. After the upper half, ready drops for a fixed acknowledge period and then returns. After the lower half, the block pulses a start strobe to a command engine and holds ready low. Ready comes back only after the engine reports completion, by which time the engine has written the mailbox's completion entry. The block records protocol misuse in a sticky error flag:

- a lower half sent with no upper half waiting;
- any doorbell write made while ready is low.

Top module: `mbxDoorbell`

## Requirements
- R1: After reset, ready is 1, the upper-half-pending flag is 0, the error flag is 0 and the start strobe is 0.
- R2: A doorbell write with bit 1 = 1 while ready is 1 stores bits 31:2 as the upper fragment and sets the pending flag. Ready then reads 0 for exactly ACK_CYCLES cycles and returns to 1.
- R3: A doorbell write with bit 1 = 0 while ready is 1 and an upper half is pending causes the following actions:
  - the start strobe rises in the next cycle and lasts exactly one cycle;
  - the mailbox address equals {upper fragment, bits 31:2 of this write} during that cycle;
  - the pending flag clears.
- R4: After a lower-half write, ready stays 0 until the done input is sampled high. Ready reads 1 in the cycle after that sample.
- R5: A lower-half write (bit 1 = 0) with no upper half pending is ignored: no start strobe and ready stays 1. It sets the error flag.
- R6: A doorbell write while ready is 0 is dropped and sets the error flag. The pending flag and the mailbox address are unchanged.
- R7: The error flag, once set, stays set until reset.
- R8: Writes to any register offset other than DB_OFFSET (default 0x160) have no effect on any output.
- R9: A read at DB_OFFSET returns {30'b0, pending flag, ready}. A read at any other offset returns 0.
- R10: A second upper-half write while the first is pending, made with ready at 1, replaces the upper fragment. The later lower half joins with the newer upper fragment.
- R11: The done input is ignored unless the block is waiting for completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte offset of the write |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Byte offset of the read |
| rdData | output | DATA_W | Read data (combinational) |
| startPulse | output | 1 | One-cycle command start to the engine |
| mbxAddr | output | 2*(DATA_W-2) | Assembled mailbox address |
| cmdDone | input | 1 | Completion from the command engine |
| protoErr | output | 1 | Sticky protocol-error flag |

## Verification
The cases that are hard to reach from the ports are the illegal writes that land inside the short windows when ready is low. These windows are the acknowledge period after an upper half and the wait for completion. The bench places writes into those windows on purpose, timed by its own cycle count after the previous write. It then reads the status back and checks the address on the next start strobe to show that the dropped write left no trace. Random fragments, random completion delays, repeated upper halves and stray writes to other offsets are mixed between legal command pairs.

// File: rtl/mbxDoorbellPkg.sv
package mbxDoorbellPkg;
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic setErr;
  } mbxStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_LAUNCH,
    ST_WAIT
  } mbxState_t;
endpackage

// File: rtl/mbxCtrl.sv
module mbxCtrl
  import mbxDoorbellPkg::*;
#(
  parameter int ACK_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrHit,
  input  logic       selHi,
  input  logic       hiPending,
  input  logic       cmdDone,
  output mbxStrobe_t strobe,
  output logic       ready,
  output logic       startPulse
);
  localparam int CNT_W = $clog2(ACK_CYCLES + 1);

  mbxState_t state;
  logic [CNT_W-1:0] ackCnt;

  always_comb begin
    strobe = '0;
    if (wrHit) begin
      if (state != ST_IDLE) strobe.setErr = 1'b1;
      else if (selHi)       strobe.loadHi = 1'b1;
      else if (hiPending)   strobe.loadLo = 1'b1;
      else                  strobe.setErr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ackCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe.loadHi) begin
            state  <= ST_ACK;
            ackCnt <= CNT_W'(ACK_CYCLES - 1);
          end else if (strobe.loadLo) begin
            state <= ST_LAUNCH;
          end
        end
        ST_ACK: begin
          if (ackCnt == '0) state <= ST_IDLE;
          else              ackCnt <= ackCnt - 1'b1;
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT:   if (cmdDone) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign ready      = (state == ST_IDLE);
  assign startPulse = (state == ST_LAUNCH);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  // R4
  start_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !ready);
  // R5
  orphan_lo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && wrHit && !selHi && !hiPending) |=> (ready && !startPulse));
  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !cmdDone) |=> !ready);
endmodule

// File: rtl/mbxData.sv
module mbxData
  import mbxDoorbellPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mbxStrobe_t              strobe,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    hiPending,
  output logic                    errFlag,
  output logic [2*(DATA_W-2)-1:0] mbxAddr
);
  localparam int FRAG_W = DATA_W - 2;

  logic [FRAG_W-1:0] hiFrag;
  logic              unusedRdyBit;

  assign unusedRdyBit = wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiFrag    <= '0;
      hiPending <= 1'b0;
      errFlag   <= 1'b0;
      mbxAddr   <= '0;
    end else begin
      if (strobe.loadHi) begin
        hiFrag    <= wrData[DATA_W-1:2];
        hiPending <= 1'b1;
      end else if (strobe.loadLo) begin
        mbxAddr   <= {hiFrag, wrData[DATA_W-1:2]};
        hiPending <= 1'b0;
      end
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

  // R3
  lo_needs_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLo |-> hiPending);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R6
  err_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setErr && !strobe.loadLo) |=> $stable(mbxAddr));
  // R2
  hi_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHi |=> hiPending);
endmodule

// File: rtl/mbxDoorbell.sv
module mbxDoorbell
  import mbxDoorbellPkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 12,
  parameter logic [11:0]     DB_OFFSET  = 12'h160,
  parameter int              ACK_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData,
  output logic                    startPulse,
  output logic [2*(DATA_W-2)-1:0] mbxAddr,
  input  logic                    cmdDone,
  output logic                    protoErr
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(DB_OFFSET);

  mbxStrobe_t strobe;
  logic       wrHit;
  logic       ready;
  logic       hiPending;

  assign wrHit = wrEn && (wrAddr == OFS);

  mbxCtrl #(.ACK_CYCLES(ACK_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .wrHit(wrHit), .selHi(wrData[1]),
    .hiPending(hiPending), .cmdDone(cmdDone), .strobe(strobe),
    .ready(ready), .startPulse(startPulse)
  );

  mbxData #(.DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .hiPending(hiPending), .errFlag(protoErr), .mbxAddr(mbxAddr)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == OFS) rdData = {{(DATA_W-2){1'b0}}, hiPending, ready};
  end
endmodule

// File: tb/mbxDoorbell_test.sv
module mbxDoorbell_test;
  localparam int ACK = 2;
  localparam logic [11:0] OFS = 12'h160;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [11:0] wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [11:0] rdAddr = OFS;
  logic [31:0] rdData;
  logic        startPulse;
  logic [59:0] mbxAddr;
  logic        cmdDone = 0;
  logic        protoErr;

  int checks = 0;
  int fails = 0;
  bit expErr = 0;

  always #2 clk = ~clk;

  mbxDoorbell uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .startPulse(startPulse),
    .mbxAddr(mbxAddr), .cmdDone(cmdDone), .protoErr(protoErr)
  );

  function automatic logic [31:0] expStatus(bit hp, bit rdy);
    return {30'b0, hp, rdy};
  endfunction

  function automatic logic [59:0] expAddr(logic [29:0] hi, logic [29:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic writeReg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  // Upper half: expect ready low for ACK cycles, then high (R2)
  task automatic sendHi(logic [29:0] hi);
    int lowCnt = 0;
    writeReg(OFS, {hi, 2'b10});
    check(rdData == expStatus(1, 0), "R2", rdData, expStatus(1, 0));
    while (!rdData[0] && lowCnt < 20) begin
      lowCnt++;
      @(negedge clk);
    end
    check(lowCnt == ACK, "R2", lowCnt, ACK);
  endtask

  task automatic sendLoRun(logic [29:0] hi, logic [29:0] lo, int delay, bit busyPoke);
    writeReg(OFS, {lo, 2'b00});
    check(startPulse == 1, "R3", startPulse, 1);
    check(mbxAddr == expAddr(hi, lo), "R3", mbxAddr, expAddr(hi, lo));
    check(rdData == expStatus(0, 0), "R3", rdData, expStatus(0, 0));
    @(negedge clk);
    check(startPulse == 0, "R3", startPulse, 0);
    for (int i = 1; i < delay; i++) begin
      if (busyPoke && i == 1) begin
        wrEn = 1; wrAddr = OFS; wrData = {~lo, 2'b10};
        @(negedge clk);
        wrEn = 0;
        expErr = 1;
        check(protoErr == 1, "R6", protoErr, 1);
        check(rdData == expStatus(0, 0), "R6", rdData, expStatus(0, 0));
        check(mbxAddr == expAddr(hi, lo), "R6", mbxAddr, expAddr(hi, lo));
      end else begin
        @(negedge clk);
      end
      check(rdData[0] == 0, "R4", rdData[0], 0);
    end
    cmdDone = 1;
    @(negedge clk);
    cmdDone = 0;
    check(rdData == expStatus(0, 1), "R4", rdData, expStatus(0, 1));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [29:0] hi, lo;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check(rdData == expStatus(0, 1), "R1", rdData, expStatus(0, 1));
    check(protoErr == 0 && startPulse == 0, "R1", {protoErr, startPulse}, 0);
    // R9 other offset reads 0
    rdAddr = 12'h164;
    @(negedge clk);
    check(rdData == 0, "R9", rdData, 0);
    rdAddr = OFS;
    // R11 done while idle
    cmdDone = 1;
    @(negedge clk);
    cmdDone = 0;
    @(negedge clk);
    check(rdData == expStatus(0, 1) && startPulse == 0, "R11", rdData, expStatus(0, 1));
    // R8 foreign offset writes
    writeReg(12'h120, 32'h0000_0002);
    check(rdData == expStatus(0, 1) && protoErr == 0, "R8", rdData, expStatus(0, 1));
    // Directed first command, no errors yet
    hi = 30'h2AAA_AAAA; lo = 30'h1555_5555;
    sendHi(hi);
    check(rdData == expStatus(1, 1), "R9", rdData, expStatus(1, 1));
    sendLoRun(hi, lo, 3, 0);
    check(protoErr == 0, "R7", protoErr, 0);
    // R5 orphan lower half
    writeReg(OFS, 32'h1234_5670);
    check(startPulse == 0 && rdData == expStatus(0, 1), "R5", rdData, expStatus(0, 1));
    check(protoErr == 1, "R5", protoErr, 1);
    expErr = 1;
    // R6 write during acknowledge window
    writeReg(OFS, {30'h3, 2'b10});
    wrEn = 1; wrAddr = OFS; wrData = 32'hFFFF_FFFC;
    @(negedge clk);
    wrEn = 0;
    repeat (ACK) @(negedge clk);
    sendLoRun(30'h3, 30'h7, 2, 0);
    // Random mix
    for (int n = 0; n < 60; n++) begin
      int kind;
      hi = 30'($urandom); lo = 30'($urandom);
      kind = int'($urandom % 4);
      if (kind == 1) writeReg(12'($urandom) & 12'hFFC | 12'h004, {hi, 2'b10}); // R8
      sendHi(hi);
      if (kind == 2) begin // R10
        hi = 30'($urandom);
        sendHi(hi);
      end
      sendLoRun(hi, lo, 1 + int'($urandom % 8), kind == 3 && ($urandom % 2 == 1));
      // R7
      check(protoErr == expErr, "R7", protoErr, expErr);
    end
    finishRun();
  end
endmodule